// File: doc/BRIEF.md
# Coprocessor Bus Decoder with Wait States

This block sits between a coprocessor core and its memories. The coprocessor has a 24-bit address space. The core presents one request at a time: a read, a write, or an idle slot for a taken jump or a branch. The block decodes the address into one target. The targets are the register window, program ROM, the battery-backed work RAM, the internal RAM, and a hole where nothing is mapped. The block then holds the request for as many cycles as that target charges. The charge depends on the region and on conflict flags that outside arbitration raises while another master holds a memory.

The block keeps a memory-address register and a memory-data register. A read from the hole returns the value last seen on the data bus. Work RAM can be seen through three views, and two high address bits pick which one. A second, purely combinational decode path serves a variable-length bit reader. That path charges no cycles, never reaches the register window, and returns all ones wherever it maps nothing. The memory arrays and the conflict arbitration live outside the block.

Top module: `cpbus_front`

## Requirements
- R1: Decode priority is register window, then ROM, then work RAM, then internal RAM, then unmapped. The `mem_tgt` codes are 0 = register window, 1 = ROM, 2 = work RAM, 3 = internal RAM, 4 = unmapped.
- R2: The register window is `(addr & 0x40FE00) == 0x002200`. A read or write there completes in exactly one cycle.
- R3: ROM is `(addr & 0x408000) == 0x008000` or `(addr & 0xC00000) == 0xC00000`. An access takes one cycle, or two when `rom_conflict` is high at the end of the first cycle.
- R4: Work RAM is `(addr & 0x40E000) == 0x006000`, or banks 0x40–0x4F, or banks 0x60–0x6F. An access takes two base cycles. In cycles 2 and 3, a high `wram_conflict` adds one more cycle each time, so an access takes two to four cycles.
- R5: Inside work RAM, `mem_view` is 2 (bitmap) when address bits 22 and 21 are both set, 1 (linear) when only bit 22 is set, and 0 (normal) otherwise.
- R6: Internal RAM is `(addr & 0x40F800)` equal to 0x000000 or 0x003000. An access takes one cycle. In cycles 1 and 2, a high `iram_conflict` adds one more cycle each time, so an access takes one to three cycles.
- R7: An unmapped access takes one cycle. An unmapped read returns the current `mdr` and leaves it unchanged.
- R8: At completion of every read or write, `mar` takes the request address. `mdr` takes the write data on every write, and the returned data on every mapped read.
- R9: The side port charges no cycles. It decodes ROM, work RAM (low-bank window and banks 0x40–0x4F only), and internal RAM. Every other address, including the register window and banks 0x60–0x6F, reads 0xFF with `vbr_tgt` = 4.
- R10: A jump idle request (`req_op` = 2) charges one cycle, plus one on `rom_conflict`, when `req_addr` (the program counter) is in ROM. Otherwise it charges none.
- R11: A branch idle request (`req_op` = 3) charges like R10 only when the program counter is odd. An even program counter charges nothing.
- R12: `req_ready` rises only in the final cycle of a request, and `req_rdata` is valid in that cycle. `cyc_charge` is high in every charged cycle. `mem_rd` and `mem_wr` pulse only in the final cycle. Op codes are 0 read, 1 write, 2 jump, 3 branch.
- R13: After reset `mar` and `mdr` are zero, and no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_op | input | 2 | 0 read, 1 write, 2 jump idle, 3 branch idle |
| req_addr | input | 24 | Access address, or program counter for idle ops |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Final cycle of the current request |
| req_rdata | output | 8 | Read data, valid with `req_ready` |
| cyc_charge | output | 1 | The current cycle is charged to the coprocessor |
| mem_tgt | output | 3 | Decoded target code |
| mem_view | output | 2 | Work RAM view code |
| mem_rd | output | 1 | Read strobe to the selected memory |
| mem_wr | output | 1 | Write strobe to the selected memory |
| mem_rdata | input | 8 | Data returned by the selected memory |
| rom_conflict | input | 1 | ROM is held by another master |
| wram_conflict | input | 1 | Work RAM is held by another master |
| iram_conflict | input | 1 | Internal RAM is held by another master |
| mar | output | 24 | Memory-address register |
| mdr | output | 8 | Memory-data register |
| vbr_addr | input | 24 | Bit-reader side address |
| vbr_tgt | output | 3 | Side-port target code |
| vbr_mem_rdata | input | 8 | Data from the memory the side port selects |
| vbr_rdata | output | 8 | Side-port read data |

## Verification
On every cycle, the assertions check these properties:
- The fixed-length cases finish on time: a register-window access in one cycle, a ROM access without conflict in one cycle, and no ROM or idle access running past its bound.
- Work RAM never finishes in its first cycle, and always finishes by its fourth. Internal RAM always finishes by its third.
- Strobes appear only with ready.
- `mar` and `mdr` follow each completed access, and an unmapped read leaves `mdr` alone.
- The side port never selects the register window.

Only the bench's scenarios can show the rest:
- The exact cycle count for each conflict pattern.
- That the right target and view are chosen at every region boundary.
- That unmapped reads return the previous bus value.
- Which program counters make an idle slot cost cycles.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 3;

    typedef enum logic [2:0] {
        TGT_IO   = 3'd0,
        TGT_ROM  = 3'd1,
        TGT_WRAM = 3'd2,
        TGT_IRAM = 3'd3,
        TGT_NONE = 3'd4
    } tgt_e;

    typedef enum logic [1:0] {
        VIEW_NORMAL = 2'd0,
        VIEW_LINEAR = 2'd1,
        VIEW_BITMAP = 2'd2
    } view_e;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_JUMP   = 2'd2,
        OP_BRANCH = 2'd3
    } op_e;

    typedef struct packed {
        tgt_e  tgt;
        view_e view;
    } dec_t;

    // Wait schedule: base cycles, then up to 'checks' conflict-gated extras.
    typedef struct packed {
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] checks;
    } cost_t;

    localparam cost_t COST_IO   = '{base: 3'd1, checks: 3'd0};
    localparam cost_t COST_ROM  = '{base: 3'd1, checks: 3'd1};
    localparam cost_t COST_WRAM = '{base: 3'd2, checks: 3'd2};
    localparam cost_t COST_IRAM = '{base: 3'd1, checks: 3'd2};
    localparam cost_t COST_NONE = '{base: 3'd1, checks: 3'd0};
    localparam cost_t COST_FREE = '{base: 3'd0, checks: 3'd0};

    function automatic logic in_io(input logic [ADDR_W-1:0] a);
        return (a & 24'h40FE00) == 24'h002200;
    endfunction

    function automatic logic in_rom(input logic [ADDR_W-1:0] a);
        return ((a & 24'h408000) == 24'h008000) || ((a & 24'hC00000) == 24'hC00000);
    endfunction

    function automatic logic in_wram_low(input logic [ADDR_W-1:0] a);
        return ((a & 24'h40E000) == 24'h006000) || (a[23:20] == 4'h4);
    endfunction

    function automatic logic in_wram_hi(input logic [ADDR_W-1:0] a);
        return a[23:20] == 4'h6;
    endfunction

    function automatic logic in_iram(input logic [ADDR_W-1:0] a);
        return ((a & 24'h40F800) == 24'h000000) || ((a & 24'h40F800) == 24'h003000);
    endfunction

endpackage

// File: rtl/cpbus_decode.sv
module cpbus_decode
    import cpbus_pkg::*;
#(
    parameter bit SIDE = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    generate
        if (SIDE) begin : g_side
            // Side path: no register window, no high work RAM banks, single view.
            always_comb begin
                dec.view = VIEW_NORMAL;
                if (in_rom(addr))           dec.tgt = TGT_ROM;
                else if (in_wram_low(addr)) dec.tgt = TGT_WRAM;
                else if (in_iram(addr))     dec.tgt = TGT_IRAM;
                else                        dec.tgt = TGT_NONE;
            end
        end else begin : g_main
            always_comb begin
                dec.view = VIEW_NORMAL;
                if (in_io(addr))                              dec.tgt = TGT_IO;
                else if (in_rom(addr))                        dec.tgt = TGT_ROM;
                else if (in_wram_low(addr) || in_wram_hi(addr)) begin
                    dec.tgt = TGT_WRAM;
                    if (addr[22] && addr[21]) dec.view = VIEW_BITMAP;
                    else if (addr[22])        dec.view = VIEW_LINEAR;
                end
                else if (in_iram(addr))                       dec.tgt = TGT_IRAM;
                else                                          dec.tgt = TGT_NONE;
            end
        end
    endgenerate
endmodule

// File: rtl/cpbus_wait.sv
module cpbus_wait
    import cpbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  cost_t cost,
    input  logic  conflict,
    output logic  done,
    output logic  charge
);
    logic             busy;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] k;
    logic [CNT_W:0]   limit;

    assign k      = busy ? idx : CNT_W'(1);
    assign limit  = {1'b0, cost.base} + {1'b0, cost.checks};
    assign charge = active && (cost.base != '0);

    always_comb begin
        if (cost.base == '0)                done = 1'b1;
        else if (k < cost.base)             done = 1'b0;
        else if ({1'b0, k} < limit)         done = !conflict;
        else                                done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (active && !done) begin
            busy <= 1'b1;
            idx  <= k + CNT_W'(1);
        end else begin
            busy <= 1'b0;
            idx  <= '0;
        end
    end
endmodule

// File: rtl/cpbus_front.sv
module cpbus_front
    import cpbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic              cyc_charge,
    output logic [2:0]        mem_tgt,
    output logic [1:0]        mem_view,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              rom_conflict,
    input  logic              wram_conflict,
    input  logic              iram_conflict,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    input  logic [ADDR_W-1:0] vbr_addr,
    output logic [2:0]        vbr_tgt,
    input  logic [DATA_W-1:0] vbr_mem_rdata,
    output logic [DATA_W-1:0] vbr_rdata
);
    dec_t  main_dec, side_dec;
    cost_t cost;
    logic  conflict_sel;
    logic  done;
    logic  is_rw, mapped;
    logic  pc_penalty;

    cpbus_decode #(.SIDE(1'b0)) u_dec_main (.addr(req_addr), .dec(main_dec));
    cpbus_decode #(.SIDE(1'b1)) u_dec_side (.addr(vbr_addr), .dec(side_dec));

    assign is_rw      = (req_op == OP_READ) || (req_op == OP_WRITE);
    assign mapped     = main_dec.tgt != TGT_NONE;
    assign pc_penalty = in_rom(req_addr) && ((req_op == OP_JUMP) || req_addr[0]);

    always_comb begin
        cost         = COST_FREE;
        conflict_sel = 1'b0;
        if (is_rw) begin
            unique case (main_dec.tgt)
                TGT_IO:   cost = COST_IO;
                TGT_ROM:  begin cost = COST_ROM;  conflict_sel = rom_conflict;  end
                TGT_WRAM: begin cost = COST_WRAM; conflict_sel = wram_conflict; end
                TGT_IRAM: begin cost = COST_IRAM; conflict_sel = iram_conflict; end
                default:  cost = COST_NONE;
            endcase
        end else if (pc_penalty) begin
            cost         = COST_ROM;
            conflict_sel = rom_conflict;
        end
    end

    cpbus_wait u_wait (
        .clk      (clk),
        .rst      (rst),
        .active   (req_valid),
        .cost     (cost),
        .conflict (conflict_sel),
        .done     (done),
        .charge   (cyc_charge)
    );

    assign req_ready = req_valid && done;
    assign mem_tgt   = main_dec.tgt;
    assign mem_view  = main_dec.view;
    assign mem_rd    = req_ready && (req_op == OP_READ) && mapped;
    assign mem_wr    = req_ready && (req_op == OP_WRITE) && mapped;
    assign req_rdata = ((req_op == OP_READ) && mapped) ? mem_rdata : mdr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mar <= '0;
            mdr <= '0;
        end else if (req_ready && is_rw) begin
            mar <= req_addr;
            if (req_op == OP_WRITE) mdr <= req_wdata;
            else if (mapped)        mdr <= mem_rdata;
        end
    end

    assign vbr_tgt   = side_dec.tgt;
    assign vbr_rdata = (side_dec.tgt == TGT_NONE) ? {DATA_W{1'b1}} : vbr_mem_rdata;
endmodule

// File: rtl/cpbus_front_chk.sv
module cpbus_front_chk
    import cpbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              req_ready,
    input logic              cyc_charge,
    input logic [2:0]        mem_tgt,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              rom_conflict,
    input logic [ADDR_W-1:0] mar,
    input logic [DATA_W-1:0] mdr,
    input logic [2:0]        vbr_tgt
);
    logic [CNT_W-1:0] elapsed;
    logic             rw;

    assign rw = !req_op[1];

    always_ff @(posedge clk) begin
        if (rst)                        elapsed <= '0;
        else if (req_valid && !req_ready) elapsed <= elapsed + CNT_W'(1);
        else                            elapsed <= '0;
    end

    p_io_single_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && rw && mem_tgt == 3'd0 |-> req_ready);

    p_rom_clear_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && rw && mem_tgt == 3'd1 && !rom_conflict |-> req_ready);

    p_rom_bound_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && mem_tgt == 3'd1 && elapsed == 3'd1 |-> req_ready);

    p_wram_min_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid && rw && mem_tgt == 3'd2 && elapsed == 3'd0 |-> !req_ready);

    p_wram_max_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid && rw && mem_tgt == 3'd2 && elapsed == 3'd3 |-> req_ready);

    p_iram_max_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && rw && mem_tgt == 3'd3 && elapsed == 3'd2 |-> req_ready);

    p_hole_keeps_mdr_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 2'd0 && mem_tgt == 3'd4 && req_ready |=> mdr == $past(mdr));

    p_write_mdr_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 2'd1 && req_ready |=> mdr == $past(req_wdata));

    p_mar_follow_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && rw && req_ready |=> mar == $past(req_addr));

    p_side_no_io_r9: assert property (@(posedge clk) disable iff (rst)
        vbr_tgt != 3'd0);

    p_even_branch_free_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == 2'd3 && !req_addr[0] |-> req_ready && !cyc_charge);

    p_strobe_final_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> req_ready);
endmodule

bind cpbus_front cpbus_front_chk u_chk (.*);

// File: tb/cpbus_front_test.sv
module cpbus_front_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [23:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic        cyc_charge;
    logic [2:0]  mem_tgt;
    logic [1:0]  mem_view;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_rdata;
    logic        rom_conflict, wram_conflict, iram_conflict;
    logic [23:0] mar;
    logic [7:0]  mdr;
    logic [23:0] vbr_addr;
    logic [2:0]  vbr_tgt;
    logic [7:0]  vbr_mem_rdata;
    logic [7:0]  vbr_rdata;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    // Memory stubs: data derived from the address.
    assign mem_rdata     = req_addr[7:0] ^ 8'hA5;
    assign vbr_mem_rdata = vbr_addr[7:0] ^ 8'h3C;

    cpbus_front uut (.*);

    // {op, addr, wdata, rom_c, wram_c, iram_c, charged cycles, tgt, view}
    localparam int NV = 25;
    localparam logic [44:0] VEC [NV] = '{
        {2'd0, 24'h002200, 8'h00, 3'b000, 3'd1, 3'd0, 2'd0},  // R2 window low edge
        {2'd0, 24'h8023FF, 8'h00, 3'b111, 3'd1, 3'd0, 2'd0},  // R2 window high edge, conflicts ignored
        {2'd0, 24'h002400, 8'h00, 3'b000, 3'd1, 3'd4, 2'd0},  // R7 just past window
        {2'd0, 24'h008000, 8'h00, 3'b000, 3'd1, 3'd1, 2'd0},  // R3 no conflict
        {2'd0, 24'h3FFFFF, 8'h00, 3'b100, 3'd2, 3'd1, 2'd0},  // R3 conflict
        {2'd0, 24'hC00000, 8'h00, 3'b100, 3'd2, 3'd1, 2'd0},  // R3 high banks
        {2'd0, 24'h006000, 8'h00, 3'b000, 3'd2, 3'd2, 2'd0},  // R4 R5 normal, base
        {2'd0, 24'hBF7FFF, 8'h00, 3'b010, 3'd4, 3'd2, 2'd0},  // R4 max
        {2'd0, 24'h400000, 8'h00, 3'b000, 3'd2, 3'd2, 2'd1},  // R5 linear
        {2'd1, 24'h4FFFFF, 8'h3C, 3'b010, 3'd4, 3'd2, 2'd1},  // R4 R8 write
        {2'd0, 24'h600000, 8'h00, 3'b010, 3'd4, 3'd2, 2'd2},  // R5 bitmap
        {2'd0, 24'h500000, 8'h00, 3'b000, 3'd1, 3'd4, 2'd0},  // R7 hole read
        {2'd0, 24'h000000, 8'h00, 3'b000, 3'd1, 3'd3, 2'd0},  // R6 base
        {2'd0, 24'h0007FF, 8'h00, 3'b001, 3'd3, 3'd3, 2'd0},  // R6 max
        {2'd1, 24'h803000, 8'h77, 3'b001, 3'd3, 3'd3, 2'd0},  // R6 write
        {2'd0, 24'h0037FF, 8'h00, 3'b000, 3'd1, 3'd3, 2'd0},  // R6 upper edge
        {2'd0, 24'h003800, 8'h00, 3'b000, 3'd1, 3'd4, 2'd0},  // R1 past internal RAM
        {2'd1, 24'h500000, 8'h99, 3'b000, 3'd1, 3'd4, 2'd0},  // R8 hole write sets mdr
        {2'd0, 24'h500001, 8'h00, 3'b000, 3'd1, 3'd4, 2'd0},  // R7 hole read returns 99
        {2'd2, 24'h008000, 8'h00, 3'b100, 3'd2, 3'd1, 2'd0},  // R10 conflict
        {2'd2, 24'h008000, 8'h00, 3'b000, 3'd1, 3'd1, 2'd0},  // R10
        {2'd2, 24'h006000, 8'h00, 3'b100, 3'd0, 3'd2, 2'd0},  // R10 pc outside ROM
        {2'd3, 24'h008001, 8'h00, 3'b100, 3'd2, 3'd1, 2'd0},  // R11 odd
        {2'd3, 24'h008000, 8'h00, 3'b100, 3'd0, 3'd1, 2'd0},  // R11 even
        {2'd2, 24'hC12345, 8'h00, 3'b000, 3'd1, 3'd1, 2'd0}   // R10 high ROM
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] mdl_mdr;
        rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0;
        rom_conflict = 1'b0; wram_conflict = 1'b0; iram_conflict = 1'b0; vbr_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R13 mar", 32'(mar), 32'h0);
        check("R13 mdr", 32'(mdr), 32'h0);
        check("R13 ready idle", 32'(req_ready), 32'h0);
        mdl_mdr = 8'h00;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [23:0] ad;
            logic [7:0]  wd, got_rd;
            logic [2:0]  exp_ch, exp_tgt, got_tgt;
            logic [1:0]  exp_view, got_view;
            int n, ch, exp_n;
            logic strobe_ok;
            {op, ad, wd, rom_conflict, wram_conflict, iram_conflict, exp_ch, exp_tgt, exp_view} = VEC[i];
            @(negedge clk);
            req_op = op; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
            n = 0; ch = 0; strobe_ok = 1'b1;
            got_rd = '0; got_tgt = '0; got_view = '0;
            for (int c = 0; c < 8; c++) begin
                #1;
                n++;
                if (cyc_charge) ch++;
                if (req_ready) begin
                    got_rd = req_rdata; got_tgt = mem_tgt; got_view = mem_view;
                    break;
                end
                if (mem_rd || mem_wr) strobe_ok = 1'b0;
                @(negedge clk);
            end
            exp_n = (exp_ch == 0) ? 1 : int'(exp_ch);
            check($sformatf("R2 R3 R4 R6 R10 R11 charged v%0d", i), 32'(ch), 32'(exp_ch));
            check($sformatf("R12 elapsed v%0d", i), 32'(n), 32'(exp_n));
            check($sformatf("R12 early strobe v%0d", i), 32'(strobe_ok), 32'h1);
            if (!op[1]) begin
                check($sformatf("R1 target v%0d", i), 32'(got_tgt), 32'(exp_tgt));
                if (exp_tgt == 3'd2)
                    check($sformatf("R5 view v%0d", i), 32'(got_view), 32'(exp_view));
                if (op == 2'd0) begin
                    if (exp_tgt == 3'd4) begin
                        check($sformatf("R7 hole data v%0d", i), 32'(got_rd), 32'(mdl_mdr));
                    end else begin
                        check($sformatf("R8 read data v%0d", i), 32'(got_rd), 32'(ad[7:0] ^ 8'hA5));
                        mdl_mdr = ad[7:0] ^ 8'hA5;
                    end
                end else begin
                    mdl_mdr = wd;
                end
            end
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            if (!op[1]) check($sformatf("R8 mar v%0d", i), 32'(mar), 32'(ad));
            check($sformatf("R7 R8 mdr v%0d", i), 32'(mdr), 32'(mdl_mdr));
        end

        // R4: conflict high in cycle 2 only gives three cycles.
        begin
            int n;
            @(negedge clk);
            rom_conflict = 1'b0; iram_conflict = 1'b0; wram_conflict = 1'b1;
            req_op = 2'd0; req_addr = 24'h406000; req_valid = 1'b1;
            n = 0;
            for (int c = 0; c < 8; c++) begin
                #1;
                n++;
                if (n == 3) wram_conflict = 1'b0;
                #1;
                if (req_ready) break;
                @(negedge clk);
            end
            check("R4 late conflict release", 32'(n), 32'd3);
            @(negedge clk);
            req_valid = 1'b0; wram_conflict = 1'b0;
        end

        // R9: side port.
        vbr_addr = 24'h002200; #1;
        check("R9 window hidden data", 32'(vbr_rdata), 32'hFF);
        check("R9 window hidden tgt", 32'(vbr_tgt), 32'd4);
        vbr_addr = 24'h008012; #1;
        check("R9 ROM data", 32'(vbr_rdata), 32'(8'h12 ^ 8'h3C));
        check("R9 ROM tgt", 32'(vbr_tgt), 32'd1);
        vbr_addr = 24'h600000; #1;
        check("R9 high wram unmapped", 32'(vbr_rdata), 32'hFF);
        vbr_addr = 24'h400010; #1;
        check("R9 linear bank wram", 32'(vbr_tgt), 32'd2);
        vbr_addr = 24'h006000; #1;
        check("R9 low window wram", 32'(vbr_tgt), 32'd2);
        vbr_addr = 24'h003000; #1;
        check("R9 iram", 32'(vbr_tgt), 32'd3);
        check("R9 no charge", 32'(cyc_charge), 32'd0);

        // R13: reset mid-access clears registers and state.
        @(negedge clk);
        req_op = 2'd0; req_addr = 24'h006000; wram_conflict = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0; wram_conflict = 1'b0; #1;
        check("R13 mar after reset", 32'(mar), 32'h0);
        check("R13 mdr after reset", 32'(mdr), 32'h0);
        @(negedge clk);
        req_op = 2'd0; req_addr = 24'h006000; req_valid = 1'b1; #1;
        check("R13 fresh count first cycle", 32'(req_ready), 32'h0);
        @(negedge clk); #1;
        check("R13 fresh count second cycle", 32'(req_ready), 32'h1);
        @(negedge clk);
        req_valid = 1'b0;

        finish_run();
    end
endmodule